// File: doc/BRIEF.md
# Compare Match Timer with Sticky Status Flag

The block is a free-running 16-bit up-counter driven by a prescaled count enable. It raises a sticky status flag each time the counter meets a programmable compare value. On that same count enable the counter returns to zero, so the timer repeats with a period of compare value plus one ticks. A level interrupt output is asserted while the flag is set and the interrupt enable is on.

Software reaches the block through a small synchronous register port with four word addresses:

| Address | Register |
|---|---|
| 0 | Control and status word |
| 1 | Counter |
| 2 | Compare value |
| 3 | Run control |

The flag is protected against blind clearing. A zero written to the flag bit removes the flag only if an earlier read of the status word returned the flag as 1.

Top module: `cmp_match_timer`

## Requirements
- R1: After reset the status word reads 0x0000, the counter reads 0, the compare register reads 0xFFFF, the run register reads 0 and `irq` is 0.
- R2: In the status word (address 0), bits 15:8 and 5:2 always read as 0, and values written to them are discarded.
- R3: Status bit 7 is the match flag. It is set on a count tick on which the counter equals the compare value. Writing 1 to bit 7 never sets it.
- R4: The flag clears only when a write of 0 to bit 7 follows a read of address 0 that returned bit 7 as 1. A write of 0 without such a read leaves the flag set.
- R5: If a match and a qualified clearing write fall in the same cycle, the flag stays set.
- R6: `irq` equals the flag ANDed with the interrupt enable, which is status bit 6.
- R7: Status bits 1:0 choose the tick rate: 00 gives clk/8, 01 gives clk/32, 10 gives clk/128 and 11 gives clk/512. The first tick comes that many clocks after counting starts.
- R8: On the tick where the counter equals the compare value, the counter goes to 0. The period is therefore compare+1 ticks.
- R9: The counter (address 1) and compare (address 2) can be written at any time. A counter write takes priority over a tick in the same cycle.
- R10: Bit 0 of address 3 is the run bit. While it is 0 the counter holds its value and the prescaler stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
The counter is read back at exact cycle offsets after the run bit is set, for compare values of 3, 0 and 0xFFFF and for three divide settings. This separates an off-by-one in the prescaler from an off-by-one in the wrap point. The clearing rule is exercised in three ways: a blind zero write, a read-armed zero write, and an armed zero write that lands on a match edge. Each of these three cases needs a different flag outcome. All-ones writes to the status word show whether reserved bits or the flag can be forced from software.

// File: rtl/cmp_match_timer.sv
`timescale 1ns/1ps
module cmp_match_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  localparam logic [1:0] A_CSR = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2, A_RUN = 2'd3;
  localparam int FLAG_B = 7, IE_B = 6;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [1:0]       cks_q;
  logic             flag_q, ie_q, armed_q, run_q;

  wire wr_csr = bus_sel && bus_wr && bus_addr == A_CSR;
  wire rd_csr = bus_sel && !bus_wr && bus_addr == A_CSR;
  wire wr_cnt = bus_sel && bus_wr && bus_addr == A_CNT;
  wire wr_cmp = bus_sel && bus_wr && bus_addr == A_CMP;
  wire wr_run = bus_sel && bus_wr && bus_addr == A_RUN;

  logic [PRE_W-1:0] div_m1;
  assign div_m1 = PRE_W'((32'd8 << {cks_q, 1'b0}) - 32'd1);

  wire tick  = run_q && pre_q >= div_m1;
  wire match = tick && cnt_q == cmp_q;
  wire clr   = wr_csr && armed_q && !bus_wdata[FLAG_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      cmp_q <= '1;
      cks_q <= '0;
      ie_q  <= 1'b0;
      flag_q <= 1'b0;
      armed_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (!run_q || tick) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;

      if (wr_cnt)     cnt_q <= bus_wdata[CNT_W-1:0];
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;

      if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
      if (wr_run) run_q <= bus_wdata[0];
      if (wr_csr) begin
        cks_q <= bus_wdata[1:0];
        ie_q  <= bus_wdata[IE_B];
      end

      if (match)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

      if (clr)                    armed_q <= 1'b0;
      else if (rd_csr && flag_q)  armed_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CSR:   bus_rdata = {8'h00, flag_q, ie_q, 4'h0, cks_q};
      A_CNT:   bus_rdata = 16'(cnt_q);
      A_CMP:   bus_rdata = 16'(cmp_q);
      default: bus_rdata = {15'h0, run_q};
    endcase
  end

  assign irq = flag_q && ie_q;

  AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && cnt_q == cmp_q)); // R3
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q && wr_csr)); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == cmp_q) |=> flag_q); // R5
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q && flag_q); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == cmp_q && !wr_cnt) |=> cnt_q == '0); // R8
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(cnt_q)); // R10
endmodule

// File: tb/cmp_match_timer_bench.sv
`timescale 1ns/1ps
module cmp_match_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;
  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  cmp_match_timer u_cmp_match_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: addr %0d actual %h expected %h", r, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string r);
    exp_q.push_back(e); req_q.push_back(r);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk_irq(input logic e, input string r);
    total++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", r, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(0, 16'h0000, "R1"); rd(1, 16'h0000, "R1");
    rd(2, 16'hFFFF, "R1"); rd(3, 16'h0000, "R1");
    chk_irq(1'b0, "R1");
    // R2, R3: all-ones write keeps reserved bits and flag at 0
    wr(0, 16'hFFFF);
    rd(0, 16'h0043, "R2_R3");
    wr(0, 16'h0000);
    rd(0, 16'h0000, "R2");
    // R7, R8: divide by 8, compare 3
    wr(2, 16'd3); wr(1, 16'd0); wr(3, 16'd1);
    idle(7);  rd(1, 16'd0, "R7");
    rd(1, 16'd1, "R7");
    idle(22); rd(1, 16'd3, "R8");
    rd(0, 16'h0080, "R3");
    rd(1, 16'd0, "R8");
    wr(3, 16'd0);
    chk_irq(1'b0, "R6");
    // R6: enable with flag set; bit7=1 write does not clear
    wr(0, 16'h00C0);
    chk_irq(1'b1, "R6");
    rd(0, 16'h00C0, "R4");
    wr(0, 16'h0040);
    rd(0, 16'h0040, "R4");
    chk_irq(1'b0, "R6");
    // R4: blind zero write has no effect
    wr(1, 16'd3); wr(3, 16'd1);
    idle(8); wr(3, 16'd0);
    wr(0, 16'h0040);
    chk_irq(1'b1, "R4");
    rd(0, 16'h00C0, "R4");
    wr(0, 16'h0040);
    rd(0, 16'h0040, "R4");
    chk_irq(1'b0, "R4");
    // R10: stopped counter holds
    wr(1, 16'd5); idle(20);
    rd(1, 16'd5, "R10");
    // R7: divide by 32
    wr(0, 16'h0001); wr(1, 16'd0); wr(2, 16'hFFFF); wr(3, 16'd1);
    idle(31); rd(1, 16'd0, "R7");
    rd(1, 16'd1, "R7");
    wr(3, 16'd0);
    // R7: divide by 512
    wr(0, 16'h0003); wr(1, 16'd0); wr(3, 16'd1);
    idle(511); rd(1, 16'd0, "R7");
    rd(1, 16'd1, "R7");
    wr(3, 16'd0);
    // R5: clearing write on a match edge, set wins
    wr(0, 16'h0000); wr(1, 16'd0); wr(2, 16'd0); wr(3, 16'd1);
    idle(8); rd(0, 16'h0080, "R5");
    idle(6); wr(0, 16'h0000);
    wr(3, 16'd0);
    rd(0, 16'h0080, "R5");
    // R9: counter write while running
    wr(2, 16'hFFFF); wr(1, 16'd0); wr(3, 16'd1);
    idle(3); wr(1, 16'h0100);
    rd(1, 16'h0100, "R9");
    wr(2, 16'h1234);
    rd(2, 16'h1234, "R9");
    wr(3, 16'd0);
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(100000 * 8);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule